// File: doc/BRIEF.md
# Floating-Point Add/Subtract Exception Pre-Detector

This block sits in front of a single-precision floating-point adder/subtractor and decides, before any significand arithmetic, whether an add or subtract might overflow or underflow. It looks only at the opcode, the two sign bits and the two biased exponent fields. When either exception is possible, it raises a bounce flag. The instruction is then handed to software, which later finds the true exception status and produces the result, instead of being completed in hardware.

Each operation is first classed as a like-signed or an unlike-signed addition. A like-signed sum can carry out of the significand and push the exponent up by one, so its overflow window is wider. It is widened by one more step so that the same check can also serve multiply-accumulate. An unlike-signed sum can cancel massively, losing up to the full significand length (24 bits) of exponent, so its underflow window is wider. The provisional result exponent reported is the larger of the two input exponents. If both operands are zero, no flag is raised.

The block uses a valid/ready handshake. When the parameter `REG_OUT` is 1, a two-state output stage holds the result. The states are `ST_EMPTY` and `ST_FULL`. The transitions are:

- IDLE: `ST_EMPTY` to `ST_EMPTY` when there is no input.
- LOAD: `ST_EMPTY` to `ST_FULL` when an input is present.
- HOLD: `ST_FULL` to `ST_FULL` when `out_ready` is low.
- REFILL: `ST_FULL` to `ST_FULL` when a result is consumed and a new input is taken in the same cycle.
- DRAIN: `ST_FULL` to `ST_EMPTY` when a result is consumed and no input is present.

With `REG_OUT` = 0, the outputs follow the inputs combinationally.

Top module: `fp_add_bounce_predict`

## Requirements
- R1: `in_op` = 0 selects add and 1 selects subtract; the sign is the operand MSB. `out_unlike` is 0 (like-signed) for an add with equal signs or a subtract with differing signs, and 1 (unlike-signed) for an add with differing signs or a subtract with equal signs.
- R2: `out_exp` equals the larger of the two biased exponent fields, which are the `EXP_W` bits just below the sign bit.
- R3: For a like-signed operation, `out_ovf` is 1 exactly when `out_exp` >= 2^EXP_W - 3 (253 by default), unless both operands are zero.
- R4: For an unlike-signed operation, `out_ovf` is 1 exactly when `out_exp` >= 2^EXP_W - 2 (254 by default), unless both operands are zero.
- R5: For an unlike-signed operation, `out_unf` is 1 exactly when `out_exp` <= FRAC_W + 2 (25 by default), unless both operands are zero.
- R6: For a like-signed operation, `out_unf` is 1 exactly when `out_exp` <= 1, unless both operands are zero.
- R7: When both operands have all exponent and fraction bits zero, `out_ovf`, `out_unf` and `out_bounce` are 0.
- R8: `out_bounce` is 1 exactly when `out_ovf` or `out_unf` is 1.
- R9: With `REG_OUT` = 1, the result of an input accepted at a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid` from that edge on. It stays unchanged while `out_valid` is high and `out_ready` is low. Results leave in acceptance order, none lost or repeated.
- R10: With `REG_OUT` = 1, `in_ready` equals `!out_valid || out_ready`. With `REG_OUT` = 0, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and the result fields reflect the present inputs in the same cycle.
- R11: Whenever the exact sum of the operands, rounded to nearest, would exceed the largest finite magnitude, or would be nonzero and below the smallest normal magnitude, `out_bounce` is 1.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1 in registered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Input can be accepted this cycle |
| in_op | input | 1 | 0 = add, 1 = subtract |
| in_a | input | 1+EXP_W+FRAC_W | First operand (sign, exponent, fraction) |
| in_b | input | 1+EXP_W+FRAC_W | Second operand (sign, exponent, fraction) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_unlike | output | 1 | 1 = unlike-signed, 0 = like-signed |
| out_exp | output | EXP_W | Provisional result exponent |
| out_ovf | output | 1 | Overflow possible |
| out_unf | output | 1 | Underflow possible |
| out_bounce | output | 1 | Hand the operation to software |

## Verification
In registered mode, the consumer can take a result in the same cycle that a new operation is accepted (the REFILL transition), and the output stage must neither drop nor repeat either. The bench provokes this with a long run of back-to-back operations while pseudo-randomly dropping `out_ready` and occasionally `in_valid`, so that HOLD, DRAIN, LOAD and REFILL all occur. Each consumed result is compared, in order, against a queue of expected flags computed arithmetically from the requirements. A combinational copy checked in the same cycle is also compared against an exact-sum reference, so that no real overflow or underflow goes unflagged.

// File: rtl/fpchk_pkg.sv
package fpchk_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } add_op_e;

    typedef enum logic {
        CLS_LIKE   = 1'b0,
        CLS_UNLIKE = 1'b1
    } add_class_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;

endpackage

// File: rtl/fpchk_classify.sv
module fpchk_classify
    import fpchk_pkg::*;
(
    input  logic       op,
    input  logic       sign_a,
    input  logic       sign_b,
    output add_class_e cls
);

    logic same_sign;
    assign same_sign = (sign_a == sign_b);

    always_comb begin
        unique case (add_op_e'(op))
            OP_ADD: cls = same_sign ? CLS_LIKE   : CLS_UNLIKE;
            OP_SUB: cls = same_sign ? CLS_UNLIKE : CLS_LIKE;
        endcase
    end

endmodule

// File: rtl/fpchk_expmax.sv
module fpchk_expmax #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W-1:0]  exp_a,
    input  logic [FRAC_W-1:0] frac_a,
    input  logic [EXP_W-1:0]  exp_b,
    input  logic [FRAC_W-1:0] frac_b,
    output logic [EXP_W-1:0]  exp_max,
    output logic              both_zero
);

    logic zero_a;
    logic zero_b;

    assign zero_a    = (exp_a == '0) && (frac_a == '0);
    assign zero_b    = (exp_b == '0) && (frac_b == '0);
    assign both_zero = zero_a && zero_b;
    assign exp_max   = (exp_a > exp_b) ? exp_a : exp_b;

endmodule

// File: rtl/fpchk_window.sv
module fpchk_window
    import fpchk_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int SIG_LEN = 24
) (
    input  add_class_e       cls,
    input  logic [EXP_W-1:0] exp_max,
    input  logic             both_zero,
    output logic             ovf,
    output logic             unf,
    output logic             bounce
);

    localparam int EXP_TOP = (1 << EXP_W) - 1;
    localparam logic [EXP_W-1:0] LIKE_OVF_LIM   = EXP_W'(EXP_TOP - 2);
    localparam logic [EXP_W-1:0] UNLIKE_OVF_LIM = EXP_W'(EXP_TOP - 1);
    localparam logic [EXP_W-1:0] UNLIKE_UNF_LIM = EXP_W'(SIG_LEN + 1);
    localparam logic [EXP_W-1:0] LIKE_UNF_LIM   = EXP_W'(1);

    logic ovf_raw;
    logic unf_raw;

    always_comb begin
        unique case (cls)
            CLS_LIKE: begin
                ovf_raw = (exp_max >= LIKE_OVF_LIM);
                unf_raw = (exp_max <= LIKE_UNF_LIM);
            end
            CLS_UNLIKE: begin
                ovf_raw = (exp_max >= UNLIKE_OVF_LIM);
                unf_raw = (exp_max <= UNLIKE_UNF_LIM);
            end
        endcase
    end

    assign ovf    = ovf_raw && !both_zero;
    assign unf    = unf_raw && !both_zero;
    assign bounce = ovf || unf;

endmodule

// File: rtl/fpchk_outstage.sv
module fpchk_outstage
    import fpchk_pkg::*;
#(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] d,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] q
);

    if (REG_OUT) begin : g_reg
        stage_state_e   state_q;
        stage_state_e   state_d;
        logic [W-1:0]   data_q;
        logic           take;

        assign take = in_valid && in_ready;

        always_ff @(posedge clk) begin
            if (rst) state_q <= ST_EMPTY;
            else     state_q <= state_d;
        end

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                ST_EMPTY: if (in_valid) state_d = ST_FULL;
                ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
            endcase
        end

        always_comb begin
            unique case (state_q)
                ST_EMPTY: begin
                    out_valid = 1'b0;
                    in_ready  = 1'b1;
                end
                ST_FULL: begin
                    out_valid = 1'b1;
                    in_ready  = out_ready;
                end
            endcase
        end

        always_ff @(posedge clk) begin
            if (take) data_q <= d;
        end

        assign q = data_q;
    end else begin : g_comb
        assign out_valid = in_valid;
        assign in_ready  = out_ready;
        assign q         = d;
    end

endmodule

// File: rtl/fp_add_bounce_predict.sv
module fp_add_bounce_predict
    import fpchk_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_op,
    input  logic [EXP_W+FRAC_W:0]   in_a,
    input  logic [EXP_W+FRAC_W:0]   in_b,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    out_unlike,
    output logic [EXP_W-1:0]        out_exp,
    output logic                    out_ovf,
    output logic                    out_unf,
    output logic                    out_bounce
);

    localparam int OP_W    = 1 + EXP_W + FRAC_W;
    localparam int SIG_LEN = FRAC_W + 1;
    localparam int PAY_W   = EXP_W + 4;

    add_class_e       cls;
    logic [EXP_W-1:0] exp_max;
    logic             both_zero;
    logic             ovf;
    logic             unf;
    logic             bounce;
    logic [PAY_W-1:0] pay_d;
    logic [PAY_W-1:0] pay_q;

    fpchk_classify u_cls (
        .op     (in_op),
        .sign_a (in_a[OP_W-1]),
        .sign_b (in_b[OP_W-1]),
        .cls    (cls)
    );

    fpchk_expmax #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_max (
        .exp_a     (in_a[OP_W-2:FRAC_W]),
        .frac_a    (in_a[FRAC_W-1:0]),
        .exp_b     (in_b[OP_W-2:FRAC_W]),
        .frac_b    (in_b[FRAC_W-1:0]),
        .exp_max   (exp_max),
        .both_zero (both_zero)
    );

    fpchk_window #(.EXP_W(EXP_W), .SIG_LEN(SIG_LEN)) u_win (
        .cls       (cls),
        .exp_max   (exp_max),
        .both_zero (both_zero),
        .ovf       (ovf),
        .unf       (unf),
        .bounce    (bounce)
    );

    assign pay_d = {cls == CLS_UNLIKE, exp_max, ovf, unf, bounce};

    fpchk_outstage #(.W(PAY_W), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d         (pay_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (pay_q)
    );

    assign {out_unlike, out_exp, out_ovf, out_unf, out_bounce} = pay_q;

endmodule

// File: rtl/fp_add_bounce_predict_chk.sv
module fp_add_bounce_predict_chk #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter bit REG_OUT = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic                  in_op,
    input logic [EXP_W+FRAC_W:0] in_a,
    input logic [EXP_W+FRAC_W:0] in_b,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic                  out_unlike,
    input logic [EXP_W-1:0]      out_exp,
    input logic                  out_ovf,
    input logic                  out_unf,
    input logic                  out_bounce
);

    localparam int EXP_TOP = (1 << EXP_W) - 1;
    localparam logic [EXP_W-1:0] LIKE_OVF_LIM   = EXP_W'(EXP_TOP - 2);
    localparam logic [EXP_W-1:0] UNLIKE_OVF_LIM = EXP_W'(EXP_TOP - 1);
    localparam logic [EXP_W-1:0] UNLIKE_UNF_LIM = EXP_W'(FRAC_W + 2);

    logic zero_in;
    assign zero_in = (in_a[EXP_W+FRAC_W-1:0] == '0) && (in_b[EXP_W+FRAC_W-1:0] == '0);

    a_r3_like_overflow: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_unlike && out_exp >= LIKE_OVF_LIM) |-> out_ovf);

    a_r4_unlike_overflow: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_unlike && out_exp >= UNLIKE_OVF_LIM) |-> out_ovf);

    a_r5_unlike_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_unlike && out_exp > UNLIKE_UNF_LIM) |-> !out_unf);

    a_r6_like_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_unlike && out_exp > EXP_W'(1)) |-> !out_unf);

    a_r8_bounce_or: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_bounce == (out_ovf || out_unf)));

    if (REG_OUT) begin : g_reg_chk
        a_r7_zero_quiet: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready && zero_in) |=> !out_bounce);

        a_r9_hold: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !out_ready) |=>
                (out_valid && $stable({out_unlike, out_exp, out_ovf, out_unf, out_bounce})));

        a_r10_ready: assert property (@(posedge clk) disable iff (rst)
            in_ready == (!out_valid || out_ready));

        a_r12_reset_empty: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !out_valid);
    end else begin : g_comb_chk
        a_r7_zero_quiet: assert property (@(posedge clk) disable iff (rst)
            (in_valid && zero_in) |-> !out_bounce);

        a_r10_pass: assert property (@(posedge clk) disable iff (rst)
            (out_valid == in_valid) && (in_ready == out_ready));
    end

endmodule

bind fp_add_bounce_predict fp_add_bounce_predict_chk #(
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_unlike (out_unlike),
    .out_exp    (out_exp),
    .out_ovf    (out_ovf),
    .out_unf    (out_unf),
    .out_bounce (out_bounce)
);

// File: tb/fp_add_bounce_predict_test.sv
`timescale 1ns/1ps
module fp_add_bounce_predict_test;

    localparam int EW    = 5;
    localparam int FW    = 4;
    localparam int OW    = 1 + EW + FW;
    localparam int EMAX  = (1 << EW) - 1;
    localparam int PW    = EW + 4;
    localparam int TOTAL = 3 * 2 * 4 * (1 << EW) * (1 << EW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          out_ready = 1'b0;
    logic          in_op = 1'b0;
    logic [OW-1:0] in_a = '0;
    logic [OW-1:0] in_b = '0;

    logic          in_ready, out_valid, out_unlike, out_ovf, out_unf, out_bounce;
    logic [EW-1:0] out_exp;
    logic          c_in_ready, c_out_valid, c_unlike, c_ovf, c_unf, c_bounce;
    logic [EW-1:0] c_exp;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fp_add_bounce_predict #(.EXP_W(EW), .FRAC_W(FW), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_unlike(out_unlike), .out_exp(out_exp),
        .out_ovf(out_ovf), .out_unf(out_unf), .out_bounce(out_bounce)
    );

    fp_add_bounce_predict #(.EXP_W(EW), .FRAC_W(FW), .REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(c_out_valid),
        .out_ready(out_ready), .out_unlike(c_unlike), .out_exp(c_exp),
        .out_ovf(c_ovf), .out_unf(c_unf), .out_bounce(c_bounce)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (op=%0d a=%h b=%h)",
                     req, act, exp_v, in_op, in_a, in_b);
        end
    endtask

    // Expected {unlike, exp, ovf, unf, bounce} from the requirements
    function automatic logic [PW-1:0] model(input logic op, input logic [OW-1:0] a,
                                            input logic [OW-1:0] b);
        int  ea, eb, mx;
        logic unl, zz, ov, un;
        ea  = int'(a[OW-2:FW]);
        eb  = int'(b[OW-2:FW]);
        mx  = (ea > eb) ? ea : eb;
        unl = op ^ a[OW-1] ^ b[OW-1];
        zz  = (a[OW-2:0] == '0) && (b[OW-2:0] == '0);
        ov  = !zz && (unl ? (mx >= EMAX - 1) : (mx >= EMAX - 2));
        un  = !zz && (unl ? (mx <= FW + 2) : (mx <= 1));
        return {unl, EW'(mx), ov, un, ov | un};
    endfunction

    // Exact-sum reference: 1 when a real overflow or underflow occurs
    function automatic logic real_exc(input logic op, input logic [OW-1:0] a,
                                      input logic [OW-1:0] b);
        int     ea, eb;
        longint na, nb, r, lim_hi, lim_lo;
        ea = int'(a[OW-2:FW]);
        eb = int'(b[OW-2:FW]);
        na = longint'({ea != 0, a[FW-1:0]}) <<< ((ea == 0) ? 1 : ea);
        nb = longint'({eb != 0, b[FW-1:0]}) <<< ((eb == 0) ? 1 : eb);
        if (a[OW-1]) na = -na;
        if (b[OW-1] ^ op) nb = -nb;
        r = na + nb;
        if (r < 0) r = -r;
        lim_hi = longint'((1 << (FW + 2)) - 1) <<< (EMAX - 2);
        lim_lo = longint'(1) <<< (FW + 1);
        return (r >= lim_hi) || ((r != 0) && (r < lim_lo));
    endfunction

    task automatic make_vec(input int idx, output logic op, output logic [OW-1:0] a,
                            output logic [OW-1:0] b);
        logic sa, sb;
        logic [EW-1:0] ea, eb;
        logic [FW-1:0] fa, fb;
        int p;
        op = idx[0];
        sa = idx[1];
        sb = idx[2];
        ea = idx[3 +: EW];
        eb = idx[3 + EW +: EW];
        p  = idx / (8 << (2 * EW));
        if (p == 0) begin
            fa = '0; fb = '0;
        end else if (p == 1) begin
            fa = '1; fb = '1;
        end else begin
            fa = FW'(int'(ea) * 3 + int'(eb) + 1);
            fb = FW'(int'(eb) * 5 + int'(ea));
        end
        a = {sa, ea, fa};
        b = {sb, eb, fb};
    endtask

    logic [PW-1:0] expq[$];

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        int idx = 0;
        logic acc;
        logic [PW-1:0] e, got;
        logic v_op;
        logic [OW-1:0] v_a, v_b;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R12 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R12 in_ready after reset", int'(in_ready), 1);

        while (idx < TOTAL || expq.size() > 0) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = lfsr[0] | lfsr[1];
            if (idx < TOTAL) begin
                make_vec(idx, v_op, v_a, v_b);
                in_op = v_op; in_a = v_a; in_b = v_b;
                in_valid = (lfsr[4:2] != 3'd0);
            end else begin
                in_valid = 1'b0;
            end
            #1;
            acc = 1'b0;
            chk(in_ready == (!out_valid || out_ready), "R10 in_ready",
                int'(in_ready), int'(!out_valid || out_ready));
            if (out_valid && out_ready) begin
                got = {out_unlike, out_exp, out_ovf, out_unf, out_bounce};
                if (expq.size() == 0) begin
                    chk(1'b0, "R9 unexpected result", int'(got), -1);
                end else begin
                    e = expq.pop_front();
                    chk(got[PW-1] == e[PW-1], "R1 class", int'(got[PW-1]), int'(e[PW-1]));
                    chk(got[PW-2:3] == e[PW-2:3], "R2 exponent", int'(got[PW-2:3]), int'(e[PW-2:3]));
                    chk(got[2] == e[2], e[PW-1] ? "R4 overflow" : "R3 overflow",
                        int'(got[2]), int'(e[2]));
                    chk(got[1] == e[1], e[PW-1] ? "R5 underflow" : "R6 underflow",
                        int'(got[1]), int'(e[1]));
                    chk(got[0] == e[0], "R8 bounce", int'(got[0]), int'(e[0]));
                end
            end
            if (in_valid && in_ready) begin
                acc = 1'b1;
                e = model(in_op, in_a, in_b);
                expq.push_back(e);
                chk({c_unlike, c_exp, c_ovf, c_unf, c_bounce} == e, "R10 comb result",
                    int'({c_unlike, c_exp, c_ovf, c_unf, c_bounce}), int'(e));
                chk(c_out_valid == in_valid && c_in_ready == out_ready, "R10 comb handshake",
                    int'({c_out_valid, c_in_ready}), int'({in_valid, out_ready}));
                if (in_a[OW-2:0] == '0 && in_b[OW-2:0] == '0)
                    chk(!c_bounce, "R7 zero operands", int'(c_bounce), 0);
                if (real_exc(in_op, in_a, in_b))
                    chk(c_bounce, "R11 real exception missed", int'(c_bounce), 1);
            end
            @(posedge clk);
            if (acc) idx++;
        end

        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R9 drained", int'(out_valid), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule